// File: doc/BRIEF.md
# Pipelined Register Bank with Parallel Outputs

This block holds a list of equal-width control registers. A host reaches them through one shared address, a write enable, a read enable, write data, read data and a read-valid strobe. Storage is a flat two-dimensional array sized by parameters, so the register count and the word width are not tied to any shared definition. The whole array is also driven out in parallel, so the datapath next to the bank can use every bit in every cycle, whatever the host is reading.

The readback multiplexer is the long path of the block, so its depth is a parameter. With one stage, a single registered mux selects the word. With two or more stages, the first stage narrows each fixed-size group of registers to one word, the second stage picks the group, and any further stages are plain delay. Readback data is not gated to zero when no read is in flight.

Reset is asynchronous and active low, and it clears only the bits named by a per-bit mask parameter. The other bits keep whatever they held, which saves routing on wide banks where only a few mode bits need a defined start value.

Top module: `preg_bank`

## Requirements
- R1: `regs_o[k]` shows the current contents of register k in every cycle, for all k at once, whether or not a read is in flight.
- R2: A write with `wr_en_i` high at a rising clock edge loads `wr_data_i` into register `addr_i` at that edge. `regs_o` shows the new value right after the edge, and a read issued in the next cycle returns it.
- R3: A write whose `addr_i` is N_REGS or greater changes no register.
- R4: `rd_vld_o` is high in exactly the cycle that starts LATENCY rising edges after the edge that accepts a read, counting the accepting edge as the first (LATENCY ≥ 1). A read is accepted on every edge where `rd_en_i` is high, including back-to-back cycles.
- R5: For an in-range address, `rd_data_o` carries the word that register `addr_i` held at the accepting edge, and it is valid while `rd_vld_o` is high.
- R6: A read whose `addr_i` is N_REGS or greater still produces `rd_vld_o` on schedule. Its data is unspecified.
- R7: While `rst_ni` is low, every bit whose position `k*DATA_W + b` is set in RST_MASK reads 0. Every bit not set in RST_MASK keeps the value it held before reset.
- R8: `rd_vld_o` is low in every cycle in which no accepted read completes.
- R9: A write changes only the addressed register. All other registers keep their contents.
- R10: A read and a write to the same register at the same edge return the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; clears only the masked bits |
| wr_en_i | input | 1 | Write request for this cycle |
| rd_en_i | input | 1 | Read request for this cycle |
| addr_i | input | ADDR_W | Register index shared by read and write |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Readback data, meaningful while rd_vld_o is high |
| rd_vld_o | output | 1 | Readback strobe, LATENCY cycles after the read |
| regs_o | output | N_REGS x DATA_W | All registers in parallel |

## Verification
A wrong write strobe or a broken storage bit shows on `regs_o` in the cycle right after the faulty edge, because the parallel output exposes the whole bank at once. A mis-steered mux stage or a wrong group select shows as bad `rd_data_o` exactly LATENCY cycles after the read that hit it. A stage missing from the valid pipeline shows as `rd_vld_o` arriving early or late against the scoreboard's due cycle. A wrong reset mask shows the moment reset is released after every register has been filled with ones: masked bits must read 0 and unmasked bits must still read 1.

// File: rtl/preg_pkg.sv
package preg_pkg;
  // index width that stays legal for a count of one
  function automatic int unsigned idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/preg_decode.sv
module preg_decode #(
  parameter int unsigned N_REGS = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_REGS-1:0] hit_o
);
  localparam logic [ADDR_W:0] N_A = (ADDR_W+1)'(N_REGS);

  for (genvar k = 0; k < N_REGS; k++) begin : g_hit
    assign hit_o[k] = wr_en_i && (addr_i == ADDR_W'(k));
  end

  assert_hit_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_o));

  assert_oob_write_dropped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ({1'b0, addr_i} >= N_A)) |-> (hit_o == '0));
endmodule

// File: rtl/preg_store.sv
module preg_store #(
  parameter int unsigned N_REGS = 8,
  parameter int unsigned DATA_W = 16,
  parameter logic [N_REGS*DATA_W-1:0] RST_MASK = '1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_REGS-1:0]              hit_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  output logic [N_REGS-1:0][DATA_W-1:0]  regs_o
);
  for (genvar r = 0; r < N_REGS; r++) begin : g_reg
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      logic bit_q;
      if (RST_MASK[r*DATA_W+b]) begin : g_rst
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)       bit_q <= 1'b0;
          else if (hit_i[r]) bit_q <= wr_data_i[b];
        end
      end else begin : g_keep
        // no reset net on this bit
        always_ff @(posedge clk_i) begin
          if (hit_i[r]) bit_q <= wr_data_i[b];
        end
      end
      assign regs_o[r][b] = bit_q;
    end

    assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_i[r] |=> (regs_o[r] == $past(wr_data_i)));

    assert_others_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hit_i[r] |=> $stable(regs_o[r]));
  end
endmodule

// File: rtl/preg_rdpipe.sv
module preg_rdpipe #(
  parameter int unsigned N_REGS   = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned LATENCY  = 2,
  parameter int unsigned GRP_SIZE = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          rd_en_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [N_REGS-1:0][DATA_W-1:0] regs_i,
  output logic [DATA_W-1:0]             rd_data_o,
  output logic                          rd_vld_o
);
  localparam int unsigned IW   = preg_pkg::idx_w(N_REGS);
  localparam logic [ADDR_W:0] N_A = (ADDR_W+1)'(N_REGS);
  localparam int unsigned CW   = $clog2(LATENCY + 2) + 1;

  // valid pipeline
  logic [LATENCY-1:0] vld_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else begin
      vld_q[0] <= rd_en_i;
      for (int i = 1; i < LATENCY; i++) vld_q[i] <= vld_q[i-1];
    end
  end
  assign rd_vld_o = vld_q[LATENCY-1];

  if (LATENCY == 1) begin : g_flat
    logic [IW-1:0]     idx;
    logic [DATA_W-1:0] data_q;
    assign idx = ({1'b0, addr_i} < N_A) ? addr_i[IW-1:0] : '0;
    always_ff @(posedge clk_i) data_q <= regs_i[idx];
    assign rd_data_o = data_q;
  end else begin : g_tree
    localparam int unsigned GW   = $clog2(GRP_SIZE);
    localparam int unsigned NGRP = (N_REGS + GRP_SIZE - 1) / GRP_SIZE;
    localparam int unsigned HW   = ADDR_W - GW;
    localparam int unsigned GIW  = preg_pkg::idx_w(NGRP);
    localparam logic [HW:0] NG_A = (HW+1)'(NGRP);

    logic [DATA_W-1:0] pad   [NGRP*GRP_SIZE];
    logic [DATA_W-1:0] grp_d [NGRP];
    logic [DATA_W-1:0] grp_q [NGRP];
    logic [HW-1:0]     hi_q;
    logic [DATA_W-1:0] sel;
    logic [DATA_W-1:0] stg_q [LATENCY-1];

    for (genvar i = 0; i < NGRP*GRP_SIZE; i++) begin : g_pad
      if (i < N_REGS) begin : g_real
        assign pad[i] = regs_i[i];
      end else begin : g_fill
        assign pad[i] = '0;
      end
    end

    // stage 1: local select inside each group
    always_comb begin
      for (int g = 0; g < NGRP; g++)
        grp_d[g] = pad[g*GRP_SIZE + int'(addr_i[GW-1:0])];
    end

    always_ff @(posedge clk_i) begin
      for (int g = 0; g < NGRP; g++) grp_q[g] <= grp_d[g];
      hi_q <= addr_i[ADDR_W-1:GW];
    end

    // stage 2: group select, then plain delay
    assign sel = ({1'b0, hi_q} < NG_A) ? grp_q[hi_q[GIW-1:0]] : grp_q[0];

    always_ff @(posedge clk_i) begin
      stg_q[0] <= sel;
      for (int s = 1; s < LATENCY-1; s++) stg_q[s] <= stg_q[s-1];
    end
    assign rd_data_o = stg_q[LATENCY-2];
  end

  // reads in flight, for the timing checks below
  logic [CW-1:0] inflight_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inflight_q <= '0;
    else inflight_q <= inflight_q + CW'(rd_en_i) - CW'(rd_vld_o);
  end

  assert_vld_has_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_o |-> (inflight_q != '0));

  assert_inflight_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_q <= CW'(LATENCY));

  assert_vld_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inflight_q == '0) |-> !rd_vld_o);
endmodule

// File: rtl/preg_bank.sv
module preg_bank #(
  parameter int unsigned N_REGS   = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned LATENCY  = 2,
  parameter int unsigned GRP_SIZE = 4,
  parameter logic [N_REGS*DATA_W-1:0] RST_MASK =
    {N_REGS{{(DATA_W/2){1'b0}}, {(DATA_W-DATA_W/2){1'b1}}}}
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic                          rd_en_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  output logic [DATA_W-1:0]             rd_data_o,
  output logic                          rd_vld_o,
  output logic [N_REGS-1:0][DATA_W-1:0] regs_o
);
  logic [N_REGS-1:0] hit;

  preg_decode #(.N_REGS(N_REGS), .ADDR_W(ADDR_W)) u_decode (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i), .hit_o(hit)
  );

  preg_store #(.N_REGS(N_REGS), .DATA_W(DATA_W), .RST_MASK(RST_MASK)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit), .wr_data_i(wr_data_i), .regs_o(regs_o)
  );

  preg_rdpipe #(
    .N_REGS(N_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .LATENCY(LATENCY), .GRP_SIZE(GRP_SIZE)
  ) u_rdpipe (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .addr_i(addr_i),
    .regs_i(regs_o), .rd_data_o(rd_data_o), .rd_vld_o(rd_vld_o)
  );
endmodule

// File: tb/preg_bank_bench.sv
`timescale 1ns/1ps
module preg_bank_bench;
  localparam int N   = 8;
  localparam int W   = 16;
  localparam int AW  = 4;
  localparam int LAT = 3;
  localparam logic [N*W-1:0] MASK = {N{8'h00, 8'hFF}};

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [W-1:0]  wr_data_i = '0;
  logic [W-1:0]  rd_data_o;
  logic          rd_vld_o;
  logic [N-1:0][W-1:0] regs_o;

  preg_bank #(.N_REGS(N), .DATA_W(W), .ADDR_W(AW), .LATENCY(LAT),
              .GRP_SIZE(4), .RST_MASK(MASK)) u_preg_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .rd_vld_o(rd_vld_o), .regs_o(regs_o)
  );

  always #5 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  typedef struct { int due; logic [W-1:0] val; logic [W-1:0] msk; string req; } exp_t;
  exp_t exp_q[$];

  logic [W-1:0] mdl [N];
  logic [W-1:0] known [N];

  function automatic logic [W-1:0] mask_of(int k);
    return MASK[k*W +: W];
  endfunction

  // monitor: pops scoreboard as results appear
  always @(negedge clk_i) begin
    if (rd_vld_o) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R8 valid with no read pending: act=1 exp=0 at cyc %0d", cyc);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        n_chk++;
        if (e.due != cyc) begin
          n_bad++;
          $display("FAIL R4 valid cycle: act=%0d exp=%0d", cyc, e.due);
        end
        n_chk++;
        if (((rd_data_o ^ e.val) & e.msk) != '0) begin
          n_bad++;
          $display("FAIL %s read data: act=%h exp=%h (mask %h)", e.req, rd_data_o, e.val, e.msk);
        end
      end
    end else if (exp_q.size() != 0 && exp_q[0].due <= cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++; n_bad++;
      $display("FAIL R4 valid missing: act=0 exp=1 due cyc %0d (%s)", e.due, e.req);
    end
  end

  // driver: one cycle of stimulus, called at a falling edge
  task automatic step(bit we, bit re, logic [AW-1:0] a, logic [W-1:0] d, string req);
    wr_en_i = we; rd_en_i = re; addr_i = a; wr_data_i = d;
    if (re) begin
      exp_t e;
      e.due = cyc + LAT;
      e.req = req;
      if (int'(a) < N) begin e.val = mdl[a]; e.msk = known[a]; end
      else begin e.val = '0; e.msk = '0; end
      exp_q.push_back(e);
    end
    if (we && int'(a) < N) begin mdl[a] = d; known[a] = '1; end
    @(negedge clk_i);
    wr_en_i = 1'b0; rd_en_i = 1'b0;
  endtask

  task automatic chk_regs(string req);
    n_chk++;
    for (int k = 0; k < N; k++) begin
      if (((regs_o[k] ^ mdl[k]) & known[k]) != '0) begin
        n_bad++;
        $display("FAIL %s regs_o[%0d]: act=%h exp=%h (mask %h)", req, k, regs_o[k], mdl[k], known[k]);
        break;
      end
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    @(negedge clk_i);
    for (int k = 0; k < N; k++) begin
      mdl[k] = mdl[k] & ~mask_of(k);
      known[k] = known[k] | mask_of(k);
    end
    chk_regs("R7 during reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic drain();
    repeat (LAT + 2) @(negedge clk_i);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    for (int k = 0; k < N; k++) begin mdl[k] = '0; known[k] = '0; end
    @(negedge clk_i);
    do_reset();
    chk_regs("R7 reset state");
    n_chk++;
    if (rd_vld_o !== 1'b0) begin n_bad++; $display("FAIL R8 idle valid: act=%b exp=0", rd_vld_o); end

    // R2 R9 R1: fill each register, whole bank checked after every write
    for (int k = 0; k < N; k++) begin
      step(1, 0, AW'(k), 16'hA500 + 16'(k * 16'h0111), "R2");
      chk_regs("R9 R1 after write");
    end

    // R5 R4: back-to-back reads of the whole bank
    for (int k = 0; k < N; k++) step(0, 1, AW'(k), '0, "R5");
    drain();

    // R2: write then read next cycle
    step(1, 0, AW'(3), 16'h1234, "R2");
    step(0, 1, AW'(3), '0, "R2 read after write");
    drain();

    // R10: read and write the same register together
    step(1, 1, AW'(5), 16'hBEEF, "R10 same-edge read");
    step(0, 1, AW'(5), '0, "R10 follow-up read");
    drain();

    // R3: out-of-range writes
    step(1, 0, AW'(9), 16'hFFFF, "R3");
    step(1, 0, AW'(15), 16'h0F0F, "R3");
    chk_regs("R3 bank unchanged");

    // R6: out-of-range read still completes
    step(0, 1, AW'(12), '0, "R6");
    step(0, 1, AW'(8), '0, "R6");
    drain();

    // mixed traffic
    lf = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0], lf[1], lf[5:2], lf ^ 16'(i), "R5 mixed");
      chk_regs("R1 mixed");
    end
    drain();

    // R8: no reads, no valid
    for (int i = 0; i < 4; i++) begin
      n_chk++;
      if (rd_vld_o !== 1'b0) begin n_bad++; $display("FAIL R8 idle valid: act=%b exp=0", rd_vld_o); end
      @(negedge clk_i);
    end

    // R7: ones everywhere, then reset clears masked bits only
    for (int k = 0; k < N; k++) step(1, 0, AW'(k), 16'hFFFF, "R2");
    do_reset();
    chk_regs("R7 mask after reset");
    for (int k = 0; k < N; k++) step(0, 1, AW'(k), '0, "R7 readback");
    drain();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule